// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Unit

This block moves 16-bit words over a clocked serial link, with a transmit channel and a receive channel that run independently of each other. Each channel has a holding stage and a shift stage. The host writes a word into the transmit holding stage, reads the last finished word from the receive buffer, and watches three status flags.

Either channel can act as the clock master or as a clock slave. As master it is clocked by an internal baud-rate generator. The generator divides one of two selectable tick sources by a programmable reload value, and the channel drives the resulting serial clock out on its own clock pin. As slave it takes its clock from that pin. The pin is brought into the system clock domain through a two-flop synchronizer and an edge detector. Because the two channels pick their clocking separately, they can run at different rates at the same time.

Data is launched on the falling edge of the serial clock and captured on the rising edge, most significant bit first. The transmit clock pin pulses only while a word is being shifted, so a slave receiver sees exactly 16 rising edges per word.

Top module: `ssio_unit`

## Requirements
- R1: After reset, tx_empty is 1, rx_full and rx_overrun are 0, tx_sd is 1, and both clock-enable outputs (tx_sck_oe, rx_sck_oe) are 0.
- R2: A word written to the transmitter in master mode, looped back to the receiver in slave mode, arrives unchanged in rx_rdata, sent most significant bit first.
- R3: In master mode each half period of the serial clock lasts reload+1 ticks of the selected source. src_sel=0 picks src_a_tick and src_sel=1 picks src_b_tick.
- R4: A clock pin is driven (its _oe output is 1) only while that channel is enabled and in master mode. While a clock pin is not driven, its output stays low.
- R5: tx_empty goes low on a write and returns high when the holding word moves into the shift register. A write made while the holding stage is full is ignored.
- R6: If the holding stage is full when a word finishes, the next word follows with no gap. Two back-to-back words complete exactly 32*(reload+1) source ticks apart.
- R7: rx_full sets when a word is copied into the receive buffer and clears only when the host pulses rx_rd.
- R8: If a word completes while rx_full is still set and no read occurs in that cycle, rx_overrun sets and rx_rdata takes the newer word. A read clears rx_full and rx_overrun together.
- R9: In slave mode the receiver samples rx_sd on each rising edge of an external rx_sck_i, most significant bit first.
- R10: In slave mode the transmitter changes tx_sd only after each falling edge of an external tx_sck_i, so the external device reads the word most significant bit first on its rising edges.
- R11: With rx_en low the receiver collects no bits, and rx_full stays 0 while traffic is present.
- R12: tx_sd rests at 1 whenever no word is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | Baud source select: 0 = src_a_tick, 1 = src_b_tick |
| src_a_tick | input | 1 | Tick enable from the first internal source |
| src_b_tick | input | 1 | Tick enable from the second internal source |
| baud_reload | input | 8 | Half-period length minus one, counted in source ticks |
| tx_en | input | 1 | Transmit channel enable |
| tx_master | input | 1 | Transmit clocking: 1 = master, 0 = slave |
| rx_en | input | 1 | Receive channel enable |
| rx_master | input | 1 | Receive clocking: 1 = master, 0 = slave |
| tx_wr | input | 1 | Write strobe for the transmit holding stage |
| tx_wdata | input | 16 | Word to transmit |
| tx_empty | output | 1 | Holding stage can accept a word |
| rx_rd | input | 1 | Read strobe; clears the receive flags |
| rx_rdata | output | 16 | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds an unread word |
| rx_overrun | output | 1 | A word was lost before it was read |
| tx_sd | output | 1 | Serial transmit data |
| tx_sck_i | input | 1 | Transmit clock pin input (slave mode) |
| tx_sck_o | output | 1 | Transmit clock pin output (master mode) |
| tx_sck_oe | output | 1 | Transmit clock pin drive enable |
| rx_sd | input | 1 | Serial receive data |
| rx_sck_i | input | 1 | Receive clock pin input (slave mode) |
| rx_sck_o | output | 1 | Receive clock pin output (master mode) |
| rx_sck_oe | output | 1 | Receive clock pin drive enable |

## Verification
tx_empty drops on the clock edge that takes a write. It rises again on the first edge after that at which the serial clock is low, so the bench checks it only after waiting for that level. A slave edge reaches the channel three system clocks after the pin changes. Because of this, the bench holds each external clock phase for at least four clocks, and it samples tx_sd just before it raises the clock. In master loopback, rx_full sets a fixed number of clocks after the 16th rising edge. The bench therefore waits for the flag with a timeout rather than at a fixed cycle. It measures clock high phases and the gap between back-to-back words as exact counts of negedge samples, and compares them with (reload+1) times the source tick spacing.

// File: rtl/ssio_pkg.sv
// Shared types for the synchronous serial unit.
package ssio_pkg;
    // Serial clock events seen in the system clock domain.
    typedef struct packed {
        logic level;   // current serial clock level
        logic rise;    // one-cycle pulse on a rising edge
        logic fall;    // one-cycle pulse on a falling edge
    } sclk_ev_t;
endpackage

// File: rtl/ssio_baudgen.sv
// Baud-rate generator. It counts ticks of the selected source and toggles a
// serial clock every RELOAD+1 ticks, giving a 50% duty clock.
// Assumes that the tick inputs are single-cycle enables in the clk domain.
// The clock idles low and is held there while run is low.
module ssio_baudgen
    import ssio_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          src_sel,
    input  logic          tick_a,
    input  logic          tick_b,
    input  logic [RW-1:0] reload,
    output sclk_ev_t      ev
);
    logic [RW-1:0] cnt_q;
    logic          lvl_q, rise_q, fall_q;
    logic          tick;

    assign tick = src_sel ? tick_b : tick_a;

    // Divide the selected tick source and toggle the serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lvl_q  <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (!run) begin
                cnt_q <= '0;
                lvl_q <= 1'b0;
            end else if (tick) begin
                if (cnt_q >= reload) begin
                    cnt_q  <= '0;
                    lvl_q  <= ~lvl_q;
                    rise_q <= ~lvl_q;
                    fall_q <= lvl_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign ev = '{level: lvl_q, rise: rise_q, fall: fall_q};
endmodule

// File: rtl/ssio_edge_sync.sv
// Slave clock input stage: a two-flop synchronizer followed by an edge
// detector. Assumes the external clock stays below one quarter of clk.
// An edge at the pin shows up as a pulse about three clocks later.
module ssio_edge_sync
    import ssio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    output sclk_ev_t ev
);
    logic s1_q, s2_q, s3_q;

    // Bring the pin into the clk domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign ev = '{level: s2_q, rise: s2_q & ~s3_q, fall: ~s2_q & s3_q};
endmodule

// File: rtl/ssio_tx.sv
// Transmit channel: a holding stage feeding a shift register, MSB first.
// It loads only while the serial clock is low, so the first bit is stable
// before the first rising edge. Each falling edge moves to the next bit.
// When a word finishes and the holding stage is full, the next word follows
// with no gap.
module ssio_tx
    import ssio_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  sclk_ev_t      ev,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          empty,
    output logic          active,
    output logic          sd
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [DW-1:0] hold_q, sh_q;
    logic          hold_full_q, active_q;
    logic [CW-1:0] cnt_q;

    // Accept host writes, load the shifter, and step one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            sh_q        <= '0;
            hold_full_q <= 1'b0;
            active_q    <= 1'b0;
            cnt_q       <= '0;
        end else begin
            if (wr && !hold_full_q) begin
                hold_q      <= wdata;
                hold_full_q <= 1'b1;
            end
            if (en) begin
                if (!active_q) begin
                    if (hold_full_q && !ev.level) begin
                        sh_q        <= hold_q;
                        hold_full_q <= 1'b0;
                        active_q    <= 1'b1;
                        cnt_q       <= '0;
                    end
                end else if (ev.fall) begin
                    if (cnt_q == LAST) begin
                        if (hold_full_q) begin
                            sh_q        <= hold_q;
                            hold_full_q <= 1'b0;
                            cnt_q       <= '0;
                        end else begin
                            active_q <= 1'b0;
                        end
                    end else begin
                        sh_q  <= {sh_q[DW-2:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign empty  = ~hold_full_q;
    assign active = active_q;
    assign sd     = active_q ? sh_q[DW-1] : 1'b1;
endmodule

// File: rtl/ssio_rx.sv
// Receive channel: shifts in one bit per rising edge, MSB first. After DW
// bits it copies the word into the receive buffer. The full flag clears on
// a read. A word that completes while the buffer is still unread sets the
// overrun flag and replaces the buffer contents.
module ssio_rx
    import ssio_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  sclk_ev_t      ev,
    input  logic          sd,
    input  logic          rd,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          overrun
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [DW-1:0] sh_q, buf_q;
    logic [CW-1:0] cnt_q;
    logic          full_q, ovr_q, done;

    assign done = en && ev.rise && (cnt_q == LAST);

    // Shift in sampled bits and copy the finished word into the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            buf_q <= '0;
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (ev.rise) begin
            sh_q <= {sh_q[DW-2:0], sd};
            if (done) begin
                buf_q <= {sh_q[DW-2:0], sd};
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Update the full and overrun flags from completions and host reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (done) begin
            full_q <= 1'b1;
            if (full_q && !rd) ovr_q <= 1'b1;
        end else if (rd) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end
    end

    assign data    = buf_q;
    assign full    = full_q;
    assign overrun = ovr_q;
endmodule

// File: rtl/ssio_unit.sv
// Full-duplex synchronous serial unit. One baud-rate generator serves
// whichever channels are in master mode, and each channel has its own slave
// clock synchronizer. Each channel picks its clock events from the generator
// or from its pin. The transmit clock pin pulses only while a word is being
// shifted; the receive clock pin runs for as long as the receiver is master.
module ssio_unit
    import ssio_pkg::*;
#(
    parameter int DW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_sel,
    input  logic          src_a_tick,
    input  logic          src_b_tick,
    input  logic [RW-1:0] baud_reload,
    input  logic          tx_en,
    input  logic          tx_master,
    input  logic          rx_en,
    input  logic          rx_master,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    output logic          tx_empty,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_rdata,
    output logic          rx_full,
    output logic          rx_overrun,
    output logic          tx_sd,
    input  logic          tx_sck_i,
    output logic          tx_sck_o,
    output logic          tx_sck_oe,
    input  logic          rx_sd,
    input  logic          rx_sck_i,
    output logic          rx_sck_o,
    output logic          rx_sck_oe
);
    localparam int NCH = 2;   // channel 0 = transmit, 1 = receive

    sclk_ev_t bg_ev;
    sclk_ev_t pin_ev [NCH];
    sclk_ev_t ch_ev  [NCH];
    logic     pins   [NCH];
    logic     is_m   [NCH];
    logic     tx_act;

    assign pins[0] = tx_sck_i;
    assign pins[1] = rx_sck_i;
    assign is_m[0] = tx_en & tx_master;
    assign is_m[1] = rx_en & rx_master;

    ssio_baudgen #(.RW(RW)) u_bg (
        .clk(clk), .rst_n(rst_n), .run(is_m[0] | is_m[1]),
        .src_sel(src_sel), .tick_a(src_a_tick), .tick_b(src_b_tick),
        .reload(baud_reload), .ev(bg_ev)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ssio_edge_sync u_sync (
            .clk(clk), .rst_n(rst_n), .pin(pins[c]), .ev(pin_ev[c])
        );
        assign ch_ev[c] = is_m[c] ? bg_ev : pin_ev[c];
    end

    ssio_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .ev(ch_ev[0]),
        .wr(tx_wr), .wdata(tx_wdata), .empty(tx_empty),
        .active(tx_act), .sd(tx_sd)
    );

    ssio_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .ev(ch_ev[1]),
        .sd(rx_sd), .rd(rx_rd), .data(rx_rdata),
        .full(rx_full), .overrun(rx_overrun)
    );

    assign tx_sck_oe = is_m[0];
    assign tx_sck_o  = is_m[0] & tx_act & bg_ev.level;
    assign rx_sck_oe = is_m[1];
    assign rx_sck_o  = is_m[1] & bg_ev.level;
endmodule

// File: rtl/ssio_unit_chk.sv
// Port-level checker for ssio_unit, attached to every instance by bind.
module ssio_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_wr,
    input logic tx_empty,
    input logic rx_rd,
    input logic rx_full,
    input logic rx_overrun,
    input logic tx_sck_o,
    input logic tx_sck_oe,
    input logic rx_sck_o,
    input logic rx_sck_oe
);
    assert_txclk_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sck_oe |-> !tx_sck_o);
    assert_rxclk_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_sck_oe |-> !rx_sck_o);
    assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_empty) |=> !tx_empty);
    assert_full_clears_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rx_rd));
    assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_full));
    assert_overrun_implies_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_full);
endmodule

bind ssio_unit ssio_unit_chk chk_i (.*);

// File: tb/ssio_unit_tb_top.sv
`timescale 1ns/1ps
module ssio_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_sel = 1'b0, src_a_tick = 1'b1, src_b_tick = 1'b0;
    logic [7:0]  baud_reload = 8'd3;
    logic        tx_en = 1'b0, tx_master = 1'b1, rx_en = 1'b0, rx_master = 1'b0;
    logic        tx_wr = 1'b0, rx_rd = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        tx_empty, rx_full, rx_overrun, tx_sd;
    logic [15:0] rx_rdata;
    logic        tx_sck_drv = 1'b0, rx_sck_drv = 1'b0, rx_sd_drv = 1'b1;
    logic        tx_sck_o, tx_sck_oe, rx_sck_o, rx_sck_oe;
    logic        loop = 1'b1;
    logic        rx_sd_w, rx_sck_w;
    int          errors = 0, checks = 0;
    int          cyc = 0;
    bit          finished = 1'b0;

    // Loopback wiring: transmitter data and clock feed the receiver pins.
    assign rx_sd_w  = loop ? tx_sd    : rx_sd_drv;
    assign rx_sck_w = loop ? tx_sck_o : rx_sck_drv;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ssio_unit dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .src_a_tick(src_a_tick),
        .src_b_tick(src_b_tick), .baud_reload(baud_reload), .tx_en(tx_en),
        .tx_master(tx_master), .rx_en(rx_en), .rx_master(rx_master),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_empty(tx_empty), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_overrun(rx_overrun),
        .tx_sd(tx_sd), .tx_sck_i(tx_sck_drv), .tx_sck_o(tx_sck_o),
        .tx_sck_oe(tx_sck_oe), .rx_sd(rx_sd_w), .rx_sck_i(rx_sck_w),
        .rx_sck_o(rx_sck_o), .rx_sck_oe(rx_sck_oe)
    );

    // Second tick source: one pulse every third clock.
    initial begin
        forever begin
            @(negedge clk) src_b_tick = 1'b0;
            @(negedge clk) src_b_tick = 1'b0;
            @(negedge clk) src_b_tick = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w);
        tx_wr = 1'b1; tx_wdata = w;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic read_pulse();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_full(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (rx_full) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 3000; i++) begin
            if (tx_empty) break;
            @(negedge clk);
        end
    endtask

    // Vectors: [24:9] word, [8:1] reload, [0] source select.
    localparam logic [24:0] VEC [4] = '{
        {16'hA5C3, 8'd3, 1'b0},
        {16'h8001, 8'd5, 1'b0},
        {16'h7FFE, 8'd1, 1'b1},
        {16'h3C96, 8'd2, 1'b1}
    };

    initial begin
        bit ok;
        int t0, hi;
        cycles(5);
        // R1: reset state.
        chk(tx_empty == 1'b1,  "R1 tx_empty", tx_empty, 1);
        chk(!rx_full && !rx_overrun, "R1 rx flags", {rx_full, rx_overrun}, 0);
        chk(tx_sd == 1'b1, "R1 tx_sd idle", tx_sd, 1);
        chk(!tx_sck_oe && !rx_sck_oe, "R1 clock pins", {tx_sck_oe, rx_sck_oe}, 0);
        rst_n = 1'b1;
        tx_en = 1'b1; tx_master = 1'b1; rx_en = 1'b1; rx_master = 1'b0;
        cycles(2);
        chk(tx_sck_oe && !rx_sck_oe, "R4 oe master/slave", {tx_sck_oe, rx_sck_oe}, 2);
        chk(tx_sd == 1'b1, "R12 idle before traffic", tx_sd, 1);

        // Vector walk: master transmit looped back to a slave receiver.
        foreach (VEC[k]) begin
            baud_reload = VEC[k][8:1];
            src_sel     = VEC[k][0];
            cycles(2);
            write_word(VEC[k][24:9]);
            chk(tx_empty == 1'b0, "R5 empty low after write", tx_empty, 0);
            hi = 0;
            for (int i = 0; i < 3000 && !tx_sck_o; i++) @(negedge clk);
            while (tx_sck_o && hi < 3000) begin hi++; @(negedge clk); end
            chk(hi == (int'(VEC[k][8:1]) + 1) * (VEC[k][0] ? 3 : 1),
                "R3 half period", hi, (int'(VEC[k][8:1]) + 1) * (VEC[k][0] ? 3 : 1));
            wait_full(ok);
            chk(ok && rx_rdata == VEC[k][24:9], "R2 loopback word", rx_rdata, VEC[k][24:9]);
            read_pulse();
            chk(rx_full == 1'b0, "R7 full cleared by read", rx_full, 0);
            cycles(3 * 2 * (int'(VEC[k][8:1]) + 1) + 8);
            chk(tx_sd == 1'b1 && tx_empty, "R12 idle after word", {tx_sd, tx_empty}, 3);
        end

        // R6 back to back, R5 write while full ignored.
        baud_reload = 8'd3; src_sel = 1'b0;
        cycles(4);
        write_word(16'h1234);
        wait_empty();
        write_word(16'hBEEF);
        chk(tx_empty == 1'b0, "R5 holding full", tx_empty, 0);
        write_word(16'hDEAD);
        wait_full(ok);
        chk(ok && rx_rdata == 16'h1234, "R6 first word", rx_rdata, 16'h1234);
        t0 = cyc;
        read_pulse();
        wait_full(ok);
        chk(ok && rx_rdata == 16'hBEEF, "R6 second word", rx_rdata, 16'hBEEF);
        chk(cyc - t0 == 32 * 4, "R6 no gap", cyc - t0, 128);
        read_pulse();
        cycles(300);
        chk(rx_full == 1'b0, "R5 third write ignored", rx_full, 0);

        // R8 overrun.
        write_word(16'h0F0F);
        wait_empty();
        write_word(16'hF0A5);
        for (int i = 0; i < 3000 && !rx_overrun; i++) @(negedge clk);
        chk(rx_overrun && rx_full, "R8 overrun set", {rx_full, rx_overrun}, 3);
        chk(rx_rdata == 16'hF0A5, "R8 newest word kept", rx_rdata, 16'hF0A5);
        read_pulse();
        chk(!rx_overrun && !rx_full, "R8 read clears", {rx_full, rx_overrun}, 0);

        // R11 receiver disabled.
        cycles(100);
        rx_en = 1'b0;
        write_word(16'h5555);
        cycles(300);
        chk(rx_full == 1'b0, "R11 disabled receiver", rx_full, 0);
        rx_en = 1'b1;

        // R4 receive master clock, transmit disabled.
        tx_en = 1'b0; rx_master = 1'b1;
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            if (rx_sck_o) hi = 1;
            @(negedge clk);
        end
        chk(rx_sck_oe && !tx_sck_oe && hi == 1, "R4 rx master clock", {rx_sck_oe, tx_sck_oe}, 2);
        rx_en = 1'b0;
        cycles(2);
        chk(!rx_sck_oe && !rx_sck_o, "R4 rx clock released", {rx_sck_oe, rx_sck_o}, 0);
        read_pulse();

        // R9 slave receive from an external clock.
        loop = 1'b0; rx_master = 1'b0; rx_en = 1'b1;
        cycles(4);
        for (int b = 15; b >= 0; b--) begin
            rx_sd_drv = 16'hC3A9 >> b;
            cycles(5);
            rx_sck_drv = 1'b1;
            cycles(5);
            rx_sck_drv = 1'b0;
        end
        cycles(6);
        chk(rx_full && rx_rdata == 16'hC3A9, "R9 slave receive", rx_rdata, 16'hC3A9);
        read_pulse();

        // R10 slave transmit to an external clock.
        rx_en = 1'b0; tx_master = 1'b0; tx_en = 1'b1;
        write_word(16'h5A3C);
        cycles(6);
        chk(tx_empty == 1'b1, "R5 loaded in slave mode", tx_empty, 1);
        begin
            logic [15:0] got = '0;
            for (int b = 15; b >= 0; b--) begin
                got[b] = tx_sd;
                rx_sck_drv = 1'b0;
                tx_sck_drv = 1'b1;
                cycles(6);
                tx_sck_drv = 1'b0;
                cycles(6);
            end
            chk(got == 16'h5A3C, "R10 slave transmit", got, 16'h5A3C);
        end
        chk(tx_sd == 1'b1, "R12 idle after slave word", tx_sd, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule